// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a freshly powered synchronous DRAM from an unknown state to one where ordinary traffic may start. After reset it holds the clock-enable and data-mask pins high and drives no-operation commands through a long settling pause. It then closes every bank and writes the mode register with a value supplied at its input. Next it issues a fixed number of auto-refresh commands. Last, it raises a ready flag. From that point the command bus carries only no-operations, so a downstream arbiter can take over.

Every interval is a parameter counted in clock cycles. The settling pause is worked out from a clock-frequency parameter and a pause length in microseconds. A nonzero override parameter replaces that figure with a short pause for simulation. The other intervals are the precharge time, the mode-set recovery time and the refresh cycle time. A reset at any moment starts the whole order again from the pause.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, cke and dqm are 1, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation), addr and ba are 0, and ready is 0.
- R2: The first command other than a no-operation is a precharge, encoded 4'b0010. It appears exactly PAUSE_CYC cycles after reset is released. PAUSE_CYC equals SIM_PAUSE_CYC when that is nonzero and CLK_MHZ*PAUSE_US otherwise.
- R3: The precharge command drives addr bit PRE_ALL_BIT (10 by default) high, which selects all banks.
- R4: The mode-register write, encoded 4'b0000, appears exactly T_RP cycles after the precharge. It carries mode_val on addr and 0 on ba.
- R5: The first auto-refresh, encoded 4'b0001, appears exactly T_RSC cycles after the mode-register write.
- R6: Exactly REF_COUNT auto-refresh commands are issued, each one T_RC cycles after the one before.
- R7: ready rises exactly T_RC cycles after the last refresh and stays high until the next reset. While ready is high, dqm is 0.
- R8: cke stays 1 for the whole sequence. Every cycle that carries no command drives a no-operation with addr equal to 0, so mode_val is visible only in the mode-write cycle. No two commands are ever issued on consecutive cycles.
- R9: Asserting reset part-way through the sequence returns the block to the R1 state. The release that follows replays the full sequence with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_val | input | ADDR_W | Value written to the device mode register |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 1 | Data mask, high during bring-up |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Bring-up complete, sticky until reset |

## Verification
The bench builds the block with SIM_PAUSE_CYC=40, T_RP=3, T_RSC=2, T_RC=7 and the default count of eight refreshes. With these values the full order finishes in about a hundred cycles, so it can be run twice in one test, with a reset dropped among the refreshes in between. T_RSC=2 is the shortest gap the timer accepts. It therefore tests the back-to-back handover between a command state and its wait state. Each command's cycle index is checked against the value computed from these parameters.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // command pin order: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_RSC,
    ST_REF,
    ST_WAIT_RC,
    ST_READY
  } boot_state_e;

  // a gap between two commands is at least two cycles (one command, one wait)
  function automatic int gap_floor2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R2: an expired timer stays expired until reloaded
  a_r2_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  // R6: a nonzero timer never jumps to zero without passing through one
  a_r6_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_boot_refcnt.sv
module sdram_boot_refcnt #(
  parameter int REF_COUNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic all_done
);

  localparam int RC_W = $clog2(REF_COUNT + 1);

  logic [RC_W-1:0] cnt_q;
  logic [RC_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clear || inc;
    cnt_d  = clear ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign all_done = (cnt_q == RC_W'(REF_COUNT));

  // R6: never more refreshes counted than required
  a_r6_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= RC_W'(REF_COUNT)));

  // R6: once complete, no further refresh is requested
  a_r6_no_extra_ref: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !inc);

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PAUSE_CYC = 25000,
  parameter int RP_GAP    = 3,
  parameter int RSC_GAP   = 2,
  parameter int RC_GAP    = 8,
  parameter int REF_COUNT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output boot_state_e state,
  output logic        ready
);

  boot_state_e      state_q;
  boot_state_e      state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             ref_clear;
  logic             ref_inc;
  logic             ref_all;

  sdram_boot_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sdram_boot_refcnt #(
    .REF_COUNT (REF_COUNT)
  ) u_refcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ref_clear),
    .inc      (ref_inc),
    .all_done (ref_all)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ref_clear = 1'b0;
    ref_inc   = 1'b0;
    unique case (state_q)
      ST_PAUSE:    if (tmr_done) state_d = ST_PRE;
      ST_PRE: begin
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(RP_GAP - 2);
        ref_clear = 1'b1;
        state_d   = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (tmr_done) state_d = ST_MRS;
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RSC_GAP - 2);
        state_d  = ST_WAIT_RSC;
      end
      ST_WAIT_RSC: if (tmr_done) state_d = ST_REF;
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RC_GAP - 2);
        ref_inc  = 1'b1;
        state_d  = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (tmr_done) state_d = ref_all ? ST_READY : ST_REF;
      end
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PAUSE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign ready = (state_q == ST_READY);

  // R2: precharge is entered only from the pause
  a_r2_pre_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> ($past(state_q) == ST_PAUSE));

  // R4: the mode write only follows the precharge wait
  a_r4_mrs_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MRS) |-> ($past(state_q) == ST_WAIT_RP));

  // R7: ready is sticky
  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R7: ready is reached only through a finished refresh wait
  a_r7_ready_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state_q) == ST_WAIT_RC));

endmodule

// File: rtl/sdram_boot_pins.sv
module sdram_boot_pins
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int PRE_ALL_BIT = 10
) (
  input  boot_state_e       state,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic              dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    cke  = 1'b1;
    dqm  = 1'b1;
    ba   = '0;
    addr = '0;
    cmd  = CMD_NOP;
    unique case (state)
      ST_PRE: begin
        cmd               = CMD_PRE;
        addr[PRE_ALL_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd  = CMD_MRS;
        addr = mode_val;
      end
      ST_REF:   cmd = CMD_REF;
      ST_READY: dqm = 1'b0;
      default:  cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int PRE_ALL_BIT   = 10,
  parameter int CLK_MHZ       = 125,
  parameter int PAUSE_US      = 200,
  parameter int SIM_PAUSE_CYC = 0,
  parameter int T_RP          = 3,
  parameter int T_RSC         = 2,
  parameter int T_RC          = 8,
  parameter int REF_COUNT     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int PAUSE_RAW = (SIM_PAUSE_CYC != 0) ? SIM_PAUSE_CYC : CLK_MHZ * PAUSE_US;
  localparam int PAUSE_CYC = gap_floor2(PAUSE_RAW);
  localparam int RP_GAP    = gap_floor2(T_RP);
  localparam int RSC_GAP   = gap_floor2(T_RSC);
  localparam int RC_GAP    = gap_floor2(T_RC);
  localparam int MAX_LOAD  = max_of4(PAUSE_CYC, RP_GAP, RSC_GAP, RC_GAP);
  localparam int CNT_W     = $clog2(MAX_LOAD + 1);

  boot_state_e state;
  logic [3:0]  cmd;

  sdram_boot_fsm #(
    .CNT_W     (CNT_W),
    .PAUSE_CYC (PAUSE_CYC),
    .RP_GAP    (RP_GAP),
    .RSC_GAP   (RSC_GAP),
    .RC_GAP    (RC_GAP),
    .REF_COUNT (REF_COUNT)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .ready (ready)
  );

  sdram_boot_pins #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .PRE_ALL_BIT (PRE_ALL_BIT)
  ) u_pins (
    .state    (state),
    .mode_val (mode_val),
    .cke      (cke),
    .cmd      (cmd),
    .dqm      (dqm),
    .ba       (ba),
    .addr     (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  // R8: no two commands on consecutive cycles
  a_r8_nop_between: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  // R6: a refresh is preceded by a no-operation cycle
  a_r6_ref_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> ($past(cmd) == CMD_NOP));

  // R7: the data mask drops only when ready rises
  a_r7_dqm_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqm) |-> $rose(ready));

endmodule

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb;

  localparam int AW    = 12;
  localparam int PAUSE = 40;
  localparam int TRP   = 3;
  localparam int TRSC  = 2;
  localparam int TRC   = 7;
  localparam int NREF  = 8;

  localparam int K_PRE = 0;
  localparam int K_MRS = 1;
  localparam int K_REF = 2;
  localparam int K_RDY = 3;

  typedef struct {
    int          kind;
    int          idx;
    logic [AW-1:0] addr;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mode_val;
  logic          cke, cs_n, ras_n, cas_n, we_n, dqm, ready;
  logic [1:0]    ba;
  logic [AW-1:0] addr;

  int    n_checks;
  int    n_fail;
  int    idx;
  int    cycles;
  bit    rdy_seen;
  item_t exp_q[$];

  sdram_boot_seq #(
    .ADDR_W        (AW),
    .SIM_PAUSE_CYC (PAUSE),
    .T_RP          (TRP),
    .T_RSC         (TRSC),
    .T_RC          (TRC),
    .REF_COUNT     (NREF)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_val (mode_val),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .dqm      (dqm),
    .ba       (ba),
    .addr     (addr),
    .ready    (ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, idx);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // expected order, indices counted from the first negedge after release
  task automatic push_sequence(input logic [AW-1:0] mv);
    item_t it;
    int t;
    t = PAUSE;
    it.kind = K_PRE; it.idx = t; it.addr = '0; it.addr[10] = 1'b1; exp_q.push_back(it); // R2 R3
    t += TRP;
    it.kind = K_MRS; it.idx = t; it.addr = mv; exp_q.push_back(it);                    // R4
    t += TRSC;
    for (int k = 0; k < NREF; k++) begin                                               // R5 R6
      it.kind = K_REF; it.idx = t; it.addr = '0; exp_q.push_back(it);
      t += TRC;
    end
    it.kind = K_RDY; it.idx = t - TRC + TRC; it.addr = '0; exp_q.push_back(it);       // R7
  endtask

  task automatic check_reset_state(input string req);
    check(cke == 1'b1, req, cke, 1);
    check(dqm == 1'b1, req, dqm, 1);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, {cs_n, ras_n, cas_n, we_n}, 7);
    check(addr == '0 && ba == '0, req, addr, 0);
    check(ready == 1'b0, req, ready, 0);
  endtask

  // monitor: pops expected items as commands appear
  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0;
      rdy_seen = 1'b0;
    end else begin
      logic [3:0] c;
      item_t it;
      int k;
      idx++;
      c = {cs_n, ras_n, cas_n, we_n};
      check(cke == 1'b1, "R8 cke", cke, 1);
      if (c != 4'b0111) begin
        k = (c == 4'b0010) ? K_PRE : (c == 4'b0000) ? K_MRS : (c == 4'b0001) ? K_REF : 9;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 extra command", k, -1);
        end else begin
          it = exp_q.pop_front();
          check(k == it.kind, (it.kind == K_PRE) ? "R2 first command" :
                (it.kind == K_MRS) ? "R4 command" : "R6 command", k, it.kind);
          check(idx == it.idx, (it.kind == K_PRE) ? "R2 timing" :
                (it.kind == K_MRS) ? "R4 timing" : "R5 R6 timing", idx, it.idx);
          if (it.kind == K_PRE) check(addr[10] == 1'b1, "R3 all-bank bit", addr[10], 1);
          if (it.kind == K_MRS) begin
            check(addr == it.addr, "R4 mode value", addr, it.addr);
            check(ba == '0, "R4 bank", ba, 0);
          end
        end
      end else if (!ready) begin
        check(addr == '0, "R8 nop address", addr, 0);
      end
      if (ready && !rdy_seen) begin
        rdy_seen = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected ready", idx, -1);
        end else begin
          it = exp_q.pop_front();
          check(it.kind == K_RDY, "R7 ready order", K_RDY, it.kind);
          check(idx == it.idx, "R7 ready timing", idx, it.idx);
        end
        check(dqm == 1'b0, "R7 dqm", dqm, 0);
      end else if (rdy_seen) begin
        check(ready == 1'b1, "R7 sticky", ready, 1);
      end
    end
  end

  // watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        check(1'b0, "watchdog", cycles, 5000);
        finish_run();
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    mode_val = 12'h5A3;
    repeat (3) @(negedge clk);
    check_reset_state("R1");

    // first run; mode_val toggles during pause and must stay off the bus (R8)
    push_sequence(12'h232);
    #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    #1 mode_val = 12'h232;
    while (!ready) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6 all items seen", exp_q.size(), 0);

    // R9: reset among the refreshes, then a full replay
    #1 rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1");
    #1 rst_n = 1'b1;
    exp_q.delete();
    push_sequence(12'h2C7);
    mode_val = 12'h2C7;
    while (idx < 60) @(negedge clk);
    #2 rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R9 reset");
    exp_q.delete();
    push_sequence(12'h0F1);
    mode_val = 12'h0F1;
    @(negedge clk);
    #1 rst_n = 1'b1;
    while (!ready) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9 replay complete", exp_q.size(), 0);
    check(ready == 1'b1 && dqm == 1'b0, "R7 final", ready, 1);
    finish_run();
  end

endmodule